// File: doc/BRIEF.md
# Constant Volts-per-Hertz Phase and Sine Generator

This block turns one speed reference sample into the quantities a three-phase modulator needs for that sample: a voltage magnitude that tracks the speed, a phase angle that advances by speed times the sample period, and signed sine and cosine values of that angle. Each accepted sample starts one fixed sequence. The sample is halved. The speed and magnitude products are formed and clamped. The 32-bit phase accumulator is advanced and wrapped. The rounded angle is folded into the first quadrant. A table index walks towards the folded angle one step per clock. The results are then presented together with a one-cycle done strobe.

Angles use integer units in which a quarter turn equals the parameter `QUARTER`, so a full turn is `4*QUARTER`. The quarter-wave table holds `ENTRIES` points. Entry i has angle `i*QUARTER/(ENTRIES-1)` (integer division) and sine `round(32767*sin(i*90deg/(ENTRIES-1)))`. Cosine is read from the same table, mirrored. The index keeps its value from one sample to the next, so when the angle moves slowly between samples the search takes few steps.

Top module: `vhz_phase_gen`

## Requirements
- R1: After reset, done is 0, mag_out, angle_out, sin_out and cos_out are 0, the phase accumulator is 0 and the table index is 1.
- R2: A sample is accepted when sample_valid is 1 while the block is idle, and it is used as sample_in shifted right arithmetically by one bit (x).
- R3: The speed is bits [31:16] of the signed product x*GAIN_W, raised to MIN_W when it is below MIN_W.
- R4: mag_out is bits [31:16] of the signed product x*GAIN_U, limited to the range MIN_U to MAX_U inclusive.
- R5: Each accepted sample adds speed*T_SAMP to the 32-bit phase accumulator. When the upper half of the sum is at or above 4*QUARTER, the value 4*QUARTER is subtracted from that upper half. The upper half never holds a value of 4*QUARTER or more.
- R6: angle_out is the accumulator's upper half plus its bit 15, which rounds it. Its value lies in 0 to 4*QUARTER.
- R7: The folded angle m and the sign flags are derived from the angle a as follows. For a <= QUARTER, m = a and both signs are positive. For a <= 2*QUARTER, m = 2*QUARTER-a and cosine is negative. For a <= 3*QUARTER, m = a-2*QUARTER and both are negative. Otherwise m = 4*QUARTER-a and sine is negative.
- R8: The index search starts from the previous index p. If the entry angle at p equals m, the index stays at p. If m is larger, the index ends at the smallest i > p whose entry angle is >= m. If m is smaller, the index ends at the largest i < p whose entry angle is <= m. The index moves by at most one per clock and stops at 0 and ENTRIES-1.
- R9: sin_out is the table sine at the final index, and cos_out is the table sine at ENTRIES-1 minus that index. Each is negated when its sign flag is negative.
- R10: done is a one-cycle pulse that rises 5+n clock edges after the edge that accepted the sample, where n is the number of index moves. The outputs change only together with done.
- R11: sample_valid is ignored while a sample is in progress. It neither changes the accumulator nor starts a second result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Accept sample_in when idle |
| sample_in | input | 16 | Signed speed reference sample |
| mag_out | output | 16 | Clamped signed voltage magnitude |
| angle_out | output | 16 | Rounded phase angle, 0 to 4*QUARTER |
| sin_out | output | 16 | Signed sine of the angle, full scale 32767 |
| cos_out | output | 16 | Signed cosine of the angle, full scale 32767 |
| done | output | 1 | One-cycle pulse when the outputs update |

## Verification
The latency of a result depends on the data, so the bench models the index walk and predicts the move count n for every sample. It then counts clock edges from the accepting edge to the first falling-edge sample that shows done high, and this count must equal 5+n. Magnitude, angle, sine and cosine are compared at that same sample point. One cycle later the bench confirms that done has dropped and that the outputs have held. Samples offered while a result is pending are left out of the bench's accumulator model, so any effect they had would appear as an angle mismatch on the next result.

// File: rtl/vhz_pkg.sv
package vhz_pkg;
  localparam int DW = 16;
  localparam int AW = 32;

  typedef logic signed [DW-1:0] sword_t;
  typedef logic [DW-1:0]        uword_t;

  typedef struct packed {
    uword_t m;
    logic   sin_neg;
    logic   cos_neg;
  } fold_t;

  // signed fractional product, upper word kept
  function automatic sword_t mul_hi(input sword_t a, input sword_t b);
    logic signed [2*DW-1:0] p;
    p = a * b;
    return sword_t'(p >>> DW);
  endfunction

  function automatic sword_t clamp_lo(input sword_t v, input sword_t lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic sword_t clamp_rng(input sword_t v, input sword_t lo, input sword_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // reduce an angle to the first quadrant, keeping the signs apart
  function automatic fold_t fold_angle(input uword_t a, input uword_t q);
    fold_t f;
    f.sin_neg = 1'b0;
    f.cos_neg = 1'b0;
    if (a <= q) begin
      f.m = a;
    end else if (a <= uword_t'(2 * q)) begin
      f.m = uword_t'(2 * q) - a;
      f.cos_neg = 1'b1;
    end else if (a <= uword_t'(3 * q)) begin
      f.m = a - uword_t'(2 * q);
      f.sin_neg = 1'b1;
      f.cos_neg = 1'b1;
    end else begin
      f.m = uword_t'(4 * q) - a;
      f.sin_neg = 1'b1;
    end
    return f;
  endfunction

  // quarter-wave sample i of n, computed at elaboration from a series
  function automatic sword_t sine_q(input int i, input int n);
    real x, x2, t, s;
    int  v;
    x  = 1.5707963267948966 * i / (n - 1);
    x2 = x * x;
    t  = x;
    s  = x;
    for (int k = 1; k < 7; k++) begin
      t = -t * x2 / ((2 * k) * (2 * k + 1));
      s = s + t;
    end
    v = $rtoi(s * 32767.0 + 0.5);
    if (v > 32767) v = 32767;
    if (v < 0) v = 0;
    return sword_t'(v);
  endfunction
endpackage

// File: rtl/vhz_scale.sv
module vhz_scale
  import vhz_pkg::*;
#(
  parameter int GAIN_W = 32767,
  parameter int GAIN_U = 32767,
  parameter int MIN_W  = 64,
  parameter int MIN_U  = 500,
  parameter int MAX_U  = 6000
) (
  input  sword_t x_in,
  output sword_t speed,
  output sword_t mag
);
  localparam sword_t KW  = sword_t'(GAIN_W);
  localparam sword_t KU  = sword_t'(GAIN_U);
  localparam sword_t WLO = sword_t'(MIN_W);
  localparam sword_t ULO = sword_t'(MIN_U);
  localparam sword_t UHI = sword_t'(MAX_U);

  assign speed = clamp_lo(mul_hi(x_in, KW), WLO);
  assign mag   = clamp_rng(mul_hi(x_in, KU), ULO, UHI);
endmodule

// File: rtl/vhz_phase_acc.sv
module vhz_phase_acc
  import vhz_pkg::*;
#(
  parameter int T_SAMP  = 4096,
  parameter int QUARTER = 5580
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step,
  input  sword_t speed,
  output uword_t acc_hi,
  output uword_t angle
);
  localparam int     TURN   = 4 * QUARTER;
  localparam uword_t TURN_U = uword_t'(TURN);
  localparam uword_t TS_U   = uword_t'(T_SAMP);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] inc;
  logic [AW-1:0] sum;
  logic [AW-1:0] acc_d;

  // speed is positive (clamped from below), so the product is too
  assign inc   = AW'($unsigned(speed)) * AW'(TS_U);
  assign sum   = acc_q + inc;
  assign acc_d = (sum[AW-1:DW] >= TURN_U) ? (sum - {TURN_U, {DW{1'b0}}}) : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (step) acc_q <= acc_d;
  end

  assign acc_hi = acc_q[AW-1:DW];
  assign angle  = acc_q[AW-1:DW] + uword_t'(acc_q[DW-1]);
endmodule

// File: rtl/vhz_quarter_lut.sv
module vhz_quarter_lut
  import vhz_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int QUARTER = 5580,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic [IW-1:0] idx_a,
  input  logic [IW-1:0] idx_b,
  output uword_t        ang_a,
  output sword_t        sin_a,
  output sword_t        sin_b
);
  sword_t sin_rom [ENTRIES];
  uword_t ang_rom [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    localparam sword_t SV = sine_q(g, ENTRIES);
    localparam uword_t AV = uword_t'((g * QUARTER) / (ENTRIES - 1));
    assign sin_rom[g] = SV;
    assign ang_rom[g] = AV;
  end

  assign ang_a = ang_rom[idx_a];
  assign sin_a = sin_rom[idx_a];
  assign sin_b = sin_rom[idx_b];
endmodule

// File: rtl/vhz_phase_gen.sv
module vhz_phase_gen
  import vhz_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int QUARTER = 5580,
  parameter int GAIN_W  = 32767,
  parameter int GAIN_U  = 32767,
  parameter int MIN_W   = 64,
  parameter int MIN_U   = 500,
  parameter int MAX_U   = 6000,
  parameter int T_SAMP  = 4096
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sample_valid,
  input  logic signed [vhz_pkg::DW-1:0] sample_in,
  output logic signed [vhz_pkg::DW-1:0] mag_out,
  output logic        [vhz_pkg::DW-1:0] angle_out,
  output logic signed [vhz_pkg::DW-1:0] sin_out,
  output logic signed [vhz_pkg::DW-1:0] cos_out,
  output logic                        done
);
  localparam int            IW   = $clog2(ENTRIES);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);
  localparam uword_t        QU   = uword_t'(QUARTER);

  typedef enum logic [2:0] {
    S_IDLE, S_SCALE, S_ACC, S_FOLD, S_SRCH0, S_UP, S_DN, S_OUT
  } state_t;

  state_t        state;
  sword_t        x_q, speed_q, mag_q;
  sword_t        speed_c, mag_c;
  uword_t        angle_q, angle_c, acc_hi;
  fold_t         fold_q, fold_c;
  logic [IW-1:0] srch_idx, mirror_idx;
  uword_t        ent_ang;
  sword_t        ent_sin, mir_sin;
  logic          acc_step;
  logic          srch_above, srch_below, at_top, at_bot;

  vhz_scale #(
    .GAIN_W(GAIN_W), .GAIN_U(GAIN_U), .MIN_W(MIN_W), .MIN_U(MIN_U), .MAX_U(MAX_U)
  ) u_scale (
    .x_in (x_q),
    .speed(speed_c),
    .mag  (mag_c)
  );

  assign acc_step = (state == S_ACC);

  vhz_phase_acc #(
    .T_SAMP(T_SAMP), .QUARTER(QUARTER)
  ) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (acc_step),
    .speed (speed_q),
    .acc_hi(acc_hi),
    .angle (angle_c)
  );

  assign fold_c     = fold_angle(angle_c, QU);
  assign mirror_idx = LAST - srch_idx;

  vhz_quarter_lut #(
    .ENTRIES(ENTRIES), .QUARTER(QUARTER)
  ) u_lut (
    .idx_a(srch_idx),
    .idx_b(mirror_idx),
    .ang_a(ent_ang),
    .sin_a(ent_sin),
    .sin_b(mir_sin)
  );

  assign srch_above = fold_q.m > ent_ang;
  assign srch_below = fold_q.m < ent_ang;
  assign at_top     = (srch_idx == LAST);
  assign at_bot     = (srch_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      x_q       <= '0;
      speed_q   <= '0;
      mag_q     <= '0;
      angle_q   <= '0;
      fold_q    <= '0;
      srch_idx  <= IW'(1);
      mag_out   <= '0;
      angle_out <= '0;
      sin_out   <= '0;
      cos_out   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (sample_valid) begin
          x_q   <= sample_in >>> 1;
          state <= S_SCALE;
        end
        S_SCALE: begin
          speed_q <= speed_c;
          mag_q   <= mag_c;
          state   <= S_ACC;
        end
        S_ACC: state <= S_FOLD;
        S_FOLD: begin
          angle_q <= angle_c;
          fold_q  <= fold_c;
          state   <= S_SRCH0;
        end
        S_SRCH0: begin
          if (srch_above && !at_top) begin
            srch_idx <= srch_idx + 1'b1;
            state    <= S_UP;
          end else if (srch_below && !at_bot) begin
            srch_idx <= srch_idx - 1'b1;
            state    <= S_DN;
          end else begin
            state <= S_OUT;
          end
        end
        S_UP: begin
          if (srch_above && !at_top) srch_idx <= srch_idx + 1'b1;
          else state <= S_OUT;
        end
        S_DN: begin
          if (srch_below && !at_bot) srch_idx <= srch_idx - 1'b1;
          else state <= S_OUT;
        end
        S_OUT: begin
          mag_out   <= mag_q;
          angle_out <= angle_q;
          sin_out   <= fold_q.sin_neg ? -ent_sin : ent_sin;
          cos_out   <= fold_q.cos_neg ? -mir_sin : mir_sin;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vhz_phase_gen_chk.sv
module vhz_phase_gen_chk #(
  parameter int ENTRIES = 32,
  parameter int QUARTER = 5580,
  parameter int MIN_U   = 500,
  parameter int MAX_U   = 6000,
  localparam int IW = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic        [15:0] angle_out,
  input logic signed [15:0] mag_out,
  input logic signed [15:0] sin_out,
  input logic signed [15:0] cos_out,
  input logic      [IW-1:0] idx,
  input logic               acc_step,
  input logic        [15:0] acc_hi
);
  localparam int TURN = 4 * QUARTER;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held"); // R10

  AST_ANGLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(angle_out) <= TURN)) else $error("angle range"); // R6

  AST_MAG_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(mag_out) >= MIN_U && int'(mag_out) <= MAX_U)) else $error("mag range"); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == $past(idx)) || (idx == $past(idx) + 1'b1) || (idx == $past(idx) - 1'b1))
    else $error("index jump"); // R8

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_step |=> $stable(acc_hi)) else $error("acc moved"); // R11

  AST_ACC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc_hi) < TURN) else $error("acc not wrapped"); // R5

  AST_Q1_SIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && int'(angle_out) <= QUARTER) |-> (sin_out >= 0 && cos_out >= 0))
    else $error("quadrant signs"); // R7
endmodule

bind vhz_phase_gen vhz_phase_gen_chk #(
  .ENTRIES(ENTRIES), .QUARTER(QUARTER), .MIN_U(MIN_U), .MAX_U(MAX_U)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .angle_out(angle_out),
  .mag_out  (mag_out),
  .sin_out  (sin_out),
  .cos_out  (cos_out),
  .idx      (srch_idx),
  .acc_step (acc_step),
  .acc_hi   (acc_hi)
);

// File: tb/vhz_phase_gen_tb.sv
module vhz_phase_gen_tb;
  localparam int N  = 32;
  localparam int Q  = 5580;
  localparam int GW = 32767;
  localparam int GU = 32767;
  localparam int WL = 64;
  localparam int UL = 500;
  localparam int UH = 6000;
  localparam int TS = 4096;
  localparam int TURN = 4 * Q;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic signed [15:0] sample_in = '0;
  logic signed [15:0] mag_out;
  logic        [15:0] angle_out;
  logic signed [15:0] sin_out;
  logic signed [15:0] cos_out;
  logic        done;

  int checks = 0;
  int errors = 0;
  longint acc_m = 0;
  int idx_m = 1;

  always #2.5 clk = ~clk;

  vhz_phase_gen #(
    .ENTRIES(N), .QUARTER(Q), .GAIN_W(GW), .GAIN_U(GU),
    .MIN_W(WL), .MIN_U(UL), .MAX_U(UH), .T_SAMP(TS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_in(sample_in),
    .mag_out(mag_out), .angle_out(angle_out), .sin_out(sin_out), .cos_out(cos_out),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ent_ang(input int i);
    return (i * Q) / (N - 1);
  endfunction

  function automatic int ent_sin(input int i);
    return $rtoi(32767.0 * $sin(3.141592653589793 * i / (2.0 * (N - 1))) + 0.5);
  endfunction

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic run_sample(input int s, input bit inject, input int junk);
    int x, w, u, a, m, sg_s, sg_c, p, nxt, lat, es, ec;
    logic signed [15:0] hs, hc;
    // bench model
    x = s >>> 1;
    w = (x * GW) >>> 16; if (w < WL) w = WL;                  // R3
    u = (x * GU) >>> 16; if (u < UL) u = UL; if (u > UH) u = UH; // R4
    acc_m = acc_m + longint'(w) * TS;                          // R5
    if ((acc_m >>> 16) >= TURN) acc_m = acc_m - (longint'(TURN) <<< 16);
    a = int'(acc_m >>> 16) + int'((acc_m >>> 15) & 1);         // R6
    // R7: quadrant fold, written by quarter number
    sg_s = 1; sg_c = 1;
    if (a <= Q) m = a;
    else if (a <= 2 * Q) begin m = 2 * Q - a; sg_c = -1; end
    else if (a <= 3 * Q) begin m = a - 2 * Q; sg_s = -1; sg_c = -1; end
    else begin m = TURN - a; sg_s = -1; end
    // R8: bracketed walk from the previous index
    p = idx_m; nxt = p;
    if (m > ent_ang(p)) begin
      while (nxt < N - 1 && ent_ang(nxt) < m) nxt++;
    end else if (m < ent_ang(p)) begin
      while (nxt > 0 && ent_ang(nxt) > m) nxt--;
    end
    idx_m = nxt;
    es = sg_s * ent_sin(nxt);
    ec = sg_c * ent_sin(N - 1 - nxt);

    // drive
    @(negedge clk);
    sample_valid = 1'b1;
    sample_in = 16'(s);
    @(posedge clk);
    @(negedge clk);
    sample_valid = inject;   // R11: offered while busy
    sample_in = 16'(junk);
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      sample_valid = 1'b0;
    end
    chk(lat == 5 + abs_i(nxt - p), "R10", "latency", lat, 5 + abs_i(nxt - p));
    chk(int'(mag_out) == u, "R4", "magnitude", mag_out, u);
    chk(int'(angle_out) == a, inject ? "R11" : "R5", "angle", angle_out, a);
    chk(abs_i(int'(sin_out) - es) <= 1, "R9", "sine", sin_out, es);
    chk(abs_i(int'(cos_out) - ec) <= 1, "R9", "cosine", cos_out, ec);
    hs = sin_out; hc = cos_out;
    @(negedge clk);
    chk(!done, "R10", "done pulse width", done, 0);
    chk(sin_out == hs && cos_out == hc, "R10", "outputs hold", sin_out, hs);
    if (inject) begin
      repeat (8) @(negedge clk);
      chk(!done, "R11", "no second result", done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!done && mag_out == 0 && angle_out == 0 && sin_out == 0 && cos_out == 0,
        "R1", "reset outputs", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done, "R1", "idle after reset", done, 0);
    // R2: sample_valid low starts nothing
    repeat (10) @(negedge clk);
    chk(!done, "R2", "no request no result", done, 0);

    // R2 R3 R4 boundary samples: zero, odd, extremes, clamp edges
    run_sample(0, 1'b0, 0);
    run_sample(1, 1'b0, 0);
    run_sample(-1, 1'b0, 0);
    run_sample(32767, 1'b0, 0);
    run_sample(-32768, 1'b0, 0);
    run_sample(12000, 1'b1, 30000);
    run_sample(1000, 1'b0, 0);
    run_sample(3277, 1'b0, 0);
    run_sample(24000, 1'b0, 0);

    // sweep of speeds across the input range, several turns
    for (int k = 0; k < 400; k++) begin
      int s;
      s = int'($signed(16'(k * 2731 + 17)));
      run_sample(s, (k % 7) == 3, k * 97);
    end

    // fast constant speed: many wraps, every quadrant in turn
    for (int k = 0; k < 250; k++) run_sample(32767, 1'b0, 0);

    // slow constant speed: single steps and equal-entry stops
    for (int k = 0; k < 150; k++) run_sample(200, 1'b0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule